// File: doc/BRIEF.md
# Out-of-Order Scheduler with Load Miss Replay

This block holds micro-operations between an upstream allocation queue and a set of execution ports. Each operation arrives with a destination tag and up to two source tags. On arrival the block matches the source tags against the tags of operations still held in its slots. This records which in-flight producers the operation must wait for. An operation becomes eligible once every recorded producer has its result available. On each port, the oldest eligible operation is granted.

Loads are issued on the assumption that they hit the data cache. Their consumers are woken a fixed hit latency after the load issues. A later hit/miss report confirms or refutes that assumption. On a hit, the speculation is retired. On a miss, the load waits for a fill, and every operation that consumed its result, directly or through a chain, returns to the waiting state. Operations that do not depend on the load keep their progress. Because this replay can happen at any time, a slot is held until every load its result depends on has been confirmed.

Top module: `oo_replay_sched`

## Requirements
- R1: After reset no port is granted and `full` is low.
- R2: `full` is high exactly when all slots are occupied, and an allocation offered while `full` is high is dropped and never issues.
- R3: An operation that depends on a non-load producer is granted no earlier than one cycle after that producer is granted. An operation with no in-flight producer is granted in the cycle after it is allocated.
- R4: An operation that depends on a load is woken speculatively and granted HIT_LAT (2) cycles after the load is granted, before the load's hit/miss outcome is known.
- R5: When several eligible operations target one port in the same cycle, the one allocated earliest is granted.
- R6: A port whose `port_rdy` bit is low receives no grant. A waiting operation for it is granted in the first cycle its bit is high.
- R7: A miss report for a load returns the load and every operation that used its result, directly or transitively, to the waiting state. The load is not granted again until a fill for its slot arrives.
- R8: An operation that does not depend on the missed load is not granted again after a miss.
- R9: After its fill, a missed load is granted again with `iss_spec` low, and its dependents follow HIT_LAT cycles later, then transitively.
- R10: A slot whose result depends on an unconfirmed load is not released, so `full` stays high while such slots fill the scheduler.
- R11: `iss_spec` is high on a grant exactly when a load is issued without a preceding fill, which marks that a hit/miss report is expected for the slot given in `iss_entry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alloc_valid | input | 1 | Allocation offered by the queue |
| alloc_tag | input | TAG_W | Destination tag of the offered operation |
| alloc_load | input | 1 | Offered operation is a load |
| alloc_port | input | PORT_W | Execution port the operation needs |
| alloc_src_a_v | input | 1 | First source tag present |
| alloc_src_a | input | TAG_W | First source tag |
| alloc_src_b_v | input | 1 | Second source tag present |
| alloc_src_b | input | TAG_W | Second source tag |
| full | output | 1 | All slots occupied; the queue must hold |
| port_rdy | input | N_PORT | Per-port acceptance this cycle |
| iss_valid | output | N_PORT | Per-port grant |
| iss_entry | output | N_PORT*IDX_W | Granted slot index per port |
| iss_tag | output | N_PORT*TAG_W | Granted destination tag per port |
| iss_spec | output | N_PORT | Grant is a speculative load issue |
| hm_valid | input | 1 | Hit/miss report present |
| hm_miss | input | 1 | Report says miss (low means hit) |
| hm_entry | input | IDX_W | Slot the report refers to |
| fill_valid | input | 1 | Miss data returned |
| fill_entry | input | IDX_W | Slot whose miss data returned |

## Verification
On every cycle, the embedded properties check several things. Each port's grant is at most one slot, and the grant is never empty while a candidate exists. A closed port gets no grant. A replayed or missed slot is back in the waiting state the next cycle, and a missed load stays blocked until its fill. A slot still carrying speculation is never released. Two kinds of behaviour can only be shown by the bench's timed scenarios. The first is the exact grant cycle after speculative wake-up and after a fill. The second is that a chain two deep is replayed while an unrelated operation is left alone, along with oldest-first ordering between competing operations and the dropping of an allocation offered while full.

// File: rtl/sched_pkg.sv
package sched_pkg;
  typedef enum logic [1:0] {
    SL_EMPTY  = 2'd0,
    SL_WAIT   = 2'd1,
    SL_ISSUED = 2'd2
  } slot_phase_e;

  // Result latency in cycles: loads use the assumed hit latency.
  function automatic int result_lat(input logic is_load, input int hit_lat);
    return is_load ? hit_lat : 1;
  endfunction
endpackage

// File: rtl/sched_alloc.sv
module sched_alloc #(
  parameter int N  = 8,
  parameter int IW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  occ,
  input  logic          req,
  output logic          full,
  output logic          accept,
  output logic [IW-1:0] idx
);
  function automatic logic [IW-1:0] first_free(input logic [N-1:0] o);
    logic [IW-1:0] r;
    r = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (!o[i]) r = IW'(i);
    end
    return r;
  endfunction

  assign full   = &occ;
  assign accept = req && !full;
  assign idx    = first_free(occ);

  // R2
  accept_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> occ[$past(idx)]);
endmodule

// File: rtl/sched_age.sv
module sched_age #(
  parameter int N  = 8,
  parameter int IW = 3,
  parameter int NP = 2,
  parameter int PW = 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   alloc_we,
  input  logic [IW-1:0]          alloc_idx,
  input  logic [N-1:0]           ready,
  input  logic [N-1:0][PW-1:0]   port_sel,
  input  logic [NP-1:0]          port_rdy,
  output logic [NP-1:0][N-1:0]   win
);
  // older[r][c]: slot r was allocated before slot c
  logic [N-1:0][N-1:0] older;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      older <= '0;
    end else if (alloc_we) begin
      for (int r = 0; r < N; r++) begin
        for (int c = 0; c < N; c++) begin
          if (r == int'(alloc_idx))      older[r][c] <= 1'b0;
          else if (c == int'(alloc_idx)) older[r][c] <= 1'b1;
        end
      end
    end
  end

  function automatic logic [N-1:0] column(input logic [N-1:0][N-1:0] m, input int c);
    logic [N-1:0] v;
    for (int r = 0; r < N; r++) v[r] = m[r][c];
    return v;
  endfunction

  for (genvar p = 0; p < NP; p++) begin : g_port
    logic [N-1:0] cand;
    always_comb begin
      for (int i = 0; i < N; i++) begin
        cand[i] = ready[i] && (int'(port_sel[i]) == p) && port_rdy[p];
      end
      for (int i = 0; i < N; i++) begin
        win[p][i] = cand[i] && ((cand & column(older, i)) == '0);
      end
    end

    // R5
    one_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(win[p]));
    // R5
    no_starve_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|cand) |-> (|win[p]));
  end
endmodule

// File: rtl/sched_slot.sv
module sched_slot
  import sched_pkg::*;
#(
  parameter int N       = 8,
  parameter int TW      = 4,
  parameter int PW      = 1,
  parameter int HIT_LAT = 2,
  localparam int CW     = $clog2(HIT_LAT + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          alloc_we,
  input  logic [TW-1:0] alloc_tag,
  input  logic          alloc_load,
  input  logic [PW-1:0] alloc_port,
  input  logic [N-1:0]  alloc_dep,
  input  logic [N-1:0]  free_vec,
  input  logic [N-1:0]  avail_ok,
  input  logic          grant,
  input  logic [N-1:0]  grant_spec,
  input  logic          replay,
  input  logic          miss_self,
  input  logic [N-1:0]  hit_clr,
  input  logic          fill_self,
  output logic          valid,
  output logic          ready,
  output logic          avail,
  output logic          releasing,
  output logic          is_load,
  output logic          filled,
  output logic [TW-1:0] tag,
  output logic [PW-1:0] port,
  output logic [N-1:0]  spec
);
  slot_phase_e  ph;
  logic         need_fill;
  logic [N-1:0] dep;
  logic [CW-1:0] cnt;

  assign valid     = (ph != SL_EMPTY);
  assign ready     = (ph == SL_WAIT) && !need_fill && ((dep & ~avail_ok) == '0);
  assign avail     = (ph == SL_ISSUED) && (cnt == '0);
  assign releasing = avail && (spec == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph <= SL_EMPTY;
      need_fill <= 1'b0;
      filled <= 1'b0;
      is_load <= 1'b0;
      tag <= '0;
      port <= '0;
      dep <= '0;
      spec <= '0;
      cnt <= '0;
    end else if (alloc_we) begin
      ph <= SL_WAIT;
      need_fill <= 1'b0;
      filled <= 1'b0;
      is_load <= alloc_load;
      tag <= alloc_tag;
      port <= alloc_port;
      dep <= alloc_dep;
      spec <= '0;
      cnt <= '0;
    end else if (ph != SL_EMPTY) begin
      dep <= dep & ~free_vec;
      if (releasing) begin
        ph <= SL_EMPTY;
      end else if (grant) begin
        ph <= SL_ISSUED;
        cnt <= CW'(result_lat(is_load, HIT_LAT) - 1);
        spec <= grant_spec;
      end else if (miss_self) begin
        ph <= SL_WAIT;
        need_fill <= 1'b1;
        spec <= '0;
        cnt <= '0;
      end else if (replay) begin
        ph <= SL_WAIT;
        spec <= '0;
        cnt <= '0;
      end else begin
        spec <= spec & ~hit_clr;
        if (cnt != '0) cnt <= cnt - 1'b1;
      end
      if (fill_self && need_fill) begin
        need_fill <= 1'b0;
        filled <= 1'b1;
      end
    end
  end

  // R3
  grant_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    grant |=> (ph == SL_ISSUED));
  // R7
  replay_back_chk: assert property (@(posedge clk) disable iff (!rst_n)
    replay |=> (ph == SL_WAIT));
  // R7
  miss_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_self && !fill_self) |=> (need_fill && !ready));
  // R10
  spec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((ph == SL_ISSUED) && (spec != '0)) |=> (ph != SL_EMPTY));
endmodule

// File: rtl/oo_replay_sched.sv
module oo_replay_sched #(
  parameter int N_SLOT  = 8,
  parameter int TAG_W   = 4,
  parameter int N_PORT  = 2,
  parameter int HIT_LAT = 2,
  localparam int IDX_W  = $clog2(N_SLOT),
  localparam int PORT_W = (N_PORT > 1) ? $clog2(N_PORT) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      alloc_valid,
  input  logic [TAG_W-1:0]          alloc_tag,
  input  logic                      alloc_load,
  input  logic [PORT_W-1:0]         alloc_port,
  input  logic                      alloc_src_a_v,
  input  logic [TAG_W-1:0]          alloc_src_a,
  input  logic                      alloc_src_b_v,
  input  logic [TAG_W-1:0]          alloc_src_b,
  output logic                      full,
  input  logic [N_PORT-1:0]         port_rdy,
  output logic [N_PORT-1:0]         iss_valid,
  output logic [N_PORT*IDX_W-1:0]   iss_entry,
  output logic [N_PORT*TAG_W-1:0]   iss_tag,
  output logic [N_PORT-1:0]         iss_spec,
  input  logic                      hm_valid,
  input  logic                      hm_miss,
  input  logic [IDX_W-1:0]          hm_entry,
  input  logic                      fill_valid,
  input  logic [IDX_W-1:0]          fill_entry
);
  localparam int N = N_SLOT;

  logic [N-1:0]                s_valid, s_ready, s_avail, s_rel, s_load, s_filled;
  logic [N-1:0][TAG_W-1:0]     s_tag;
  logic [N-1:0][PORT_W-1:0]    s_port;
  logic [N-1:0][N-1:0]         s_spec, grant_spec;
  logic [N-1:0]                alloc_dep, avail_ok, grant, replay_vec, miss_vec, hit_clr;
  logic [N_PORT-1:0][N-1:0]    win;
  logic                        accept;
  logic [IDX_W-1:0]            alloc_idx;
  logic                        hm_own, miss_now, hit_now;

  function automatic logic [IDX_W-1:0] to_index(input logic [N-1:0] v);
    logic [IDX_W-1:0] r;
    r = '0;
    for (int j = 0; j < N; j++) if (v[j]) r = IDX_W'(j);
    return r;
  endfunction

  function automatic logic src_hit(input logic v, input logic [TAG_W-1:0] s,
                                   input logic [TAG_W-1:0] t);
    return v && (s == t);
  endfunction

  sched_alloc #(.N(N), .IW(IDX_W)) u_alloc (
    .clk(clk), .rst_n(rst_n), .occ(s_valid), .req(alloc_valid),
    .full(full), .accept(accept), .idx(alloc_idx)
  );

  // Outcome report counts only for a slot still carrying its own speculation.
  assign hm_own   = hm_valid && s_spec[hm_entry][hm_entry];
  assign miss_now = hm_own && hm_miss;
  assign hit_now  = hm_own && !hm_miss;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      miss_vec[i]   = miss_now && (i == int'(hm_entry));
      hit_clr[i]    = hit_now && (i == int'(hm_entry));
      replay_vec[i] = miss_now && s_spec[i][hm_entry] && (i != int'(hm_entry));
      alloc_dep[i]  = s_valid[i] && !s_rel[i] &&
                      (src_hit(alloc_src_a_v, alloc_src_a, s_tag[i]) ||
                       src_hit(alloc_src_b_v, alloc_src_b, s_tag[i]));
    end
    avail_ok = s_avail & ~replay_vec & ~miss_vec;
  end

  logic [N-1:0][N-1:0] s_dep_unused;
  assign s_dep_unused = '0;

  sched_age #(.N(N), .IW(IDX_W), .NP(N_PORT), .PW(PORT_W)) u_age (
    .clk(clk), .rst_n(rst_n), .alloc_we(accept), .alloc_idx(alloc_idx),
    .ready(s_ready), .port_sel(s_port), .port_rdy(port_rdy), .win(win)
  );

  always_comb begin
    grant = '0;
    for (int p = 0; p < N_PORT; p++) grant |= win[p];
  end

  // Speculation inherited from producers, minus what is confirmed this cycle.
  logic [N-1:0][N-1:0] prod_of;
  always_comb begin
    for (int i = 0; i < N; i++) begin
      grant_spec[i] = '0;
      for (int j = 0; j < N; j++) begin
        if (prod_of[i][j]) grant_spec[i] = grant_spec[i] | s_spec[j];
      end
      grant_spec[i] = grant_spec[i] & ~hit_clr;
      if (s_load[i] && !s_filled[i]) grant_spec[i][i] = 1'b1;
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_slot
    logic [N-1:0] dep_view;
    sched_slot #(.N(N), .TW(TAG_W), .PW(PORT_W), .HIT_LAT(HIT_LAT)) u_slot (
      .clk(clk), .rst_n(rst_n),
      .alloc_we(accept && (alloc_idx == IDX_W'(i))),
      .alloc_tag(alloc_tag), .alloc_load(alloc_load), .alloc_port(alloc_port),
      .alloc_dep(alloc_dep), .free_vec(s_rel), .avail_ok(avail_ok),
      .grant(grant[i]), .grant_spec(grant_spec[i]),
      .replay(replay_vec[i]), .miss_self(miss_vec[i]), .hit_clr(hit_clr),
      .fill_self(fill_valid && (fill_entry == IDX_W'(i))),
      .valid(s_valid[i]), .ready(s_ready[i]), .avail(s_avail[i]),
      .releasing(s_rel[i]), .is_load(s_load[i]), .filled(s_filled[i]),
      .tag(s_tag[i]), .port(s_port[i]), .spec(s_spec[i])
    );
    // producer set seen by the slot: its waiting dependencies or, once
    // issued, the producers whose speculation it absorbed at grant time
    assign dep_view = u_slot.dep;
    assign prod_of[i] = dep_view | s_dep_unused[i];
  end

  for (genvar p = 0; p < N_PORT; p++) begin : g_out
    logic [IDX_W-1:0] w_idx;
    assign w_idx = to_index(win[p]);
    assign iss_valid[p] = |win[p];
    assign iss_entry[p*IDX_W +: IDX_W] = w_idx;
    assign iss_tag[p*TAG_W +: TAG_W]   = s_tag[w_idx];
    assign iss_spec[p] = (|win[p]) && s_load[w_idx] && !s_filled[w_idx];

    // R6
    port_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !port_rdy[p] |-> !iss_valid[p]);
    // R11
    spec_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (iss_valid[p] && iss_spec[p]) |=> s_spec[$past(w_idx)][$past(w_idx)] || !$past(rst_n));
  end
endmodule

// File: tb/test_oo_replay_sched.sv
module test_oo_replay_sched;
  localparam int N = 8, TW = 4, NP = 2, HL = 2;
  localparam int IW = $clog2(N);

  logic clk = 0, rst_n = 0;
  logic alloc_valid = 0, alloc_load = 0, alloc_src_a_v = 0, alloc_src_b_v = 0;
  logic [TW-1:0] alloc_tag = 0, alloc_src_a = 0, alloc_src_b = 0;
  logic [0:0] alloc_port = 0;
  logic full;
  logic [NP-1:0] port_rdy = '1, iss_valid, iss_spec;
  logic [NP*IW-1:0] iss_entry;
  logic [NP*TW-1:0] iss_tag;
  logic hm_valid = 0, hm_miss = 0, fill_valid = 0;
  logic [IW-1:0] hm_entry = 0, fill_entry = 0;

  oo_replay_sched i_oo_replay_sched (
    .clk(clk), .rst_n(rst_n), .alloc_valid(alloc_valid), .alloc_tag(alloc_tag),
    .alloc_load(alloc_load), .alloc_port(alloc_port), .alloc_src_a_v(alloc_src_a_v),
    .alloc_src_a(alloc_src_a), .alloc_src_b_v(alloc_src_b_v), .alloc_src_b(alloc_src_b),
    .full(full), .port_rdy(port_rdy), .iss_valid(iss_valid), .iss_entry(iss_entry),
    .iss_tag(iss_tag), .iss_spec(iss_spec), .hm_valid(hm_valid), .hm_miss(hm_miss),
    .hm_entry(hm_entry), .fill_valid(fill_valid), .fill_entry(fill_entry)
  );

  always #2.5 clk = ~clk;

  typedef struct { int cyc; int port; int tag; bit spec; string req; } exp_t;
  exp_t q[$];
  int cyc = 0, checks = 0, fails = 0;
  int entry_of[16];
  bit run = 0, done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string r, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", r, what, act, expv, cyc);
    end
  endtask

  task automatic exp_iss(input int c, input int p, input int t, input bit s, input string r);
    exp_t e;
    e.cyc = c; e.port = p; e.tag = t; e.spec = s; e.req = r;
    q.push_back(e);
  endtask

  // scoreboard monitor, samples mid-cycle
  always @(negedge clk) if (run) begin
    for (int p = 0; p < NP; p++) begin
      if (iss_valid[p]) begin
        int t;
        t = int'(iss_tag[p*TW +: TW]);
        entry_of[t] = int'(iss_entry[p*IW +: IW]);
        if (q.size() > 0 && q[0].cyc == cyc && q[0].port == p) begin
          chk(t == q[0].tag, q[0].req, "issued tag", t, q[0].tag);
          chk(iss_spec[p] == q[0].spec, q[0].req, "iss_spec", int'(iss_spec[p]), int'(q[0].spec));
          void'(q.pop_front());
        end else begin
          chk(1'b0, "R8", "unexpected grant tag", t, -1);
        end
      end
    end
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      chk(1'b0, q[0].req, "missing grant tag", -1, q[0].tag);
      void'(q.pop_front());
    end
  end

  task automatic nxt();
    @(posedge clk); #1;
    alloc_valid = 0; hm_valid = 0; fill_valid = 0;
  endtask

  task automatic alloc(input int t, input bit ld, input int p, input int sa, input int sb);
    alloc_valid = 1; alloc_tag = TW'(t); alloc_load = ld; alloc_port = 1'(p);
    alloc_src_a_v = (sa >= 0); alloc_src_a = TW'(sa < 0 ? 0 : sa);
    alloc_src_b_v = (sb >= 0); alloc_src_b = TW'(sb < 0 ? 0 : sb);
  endtask

  task automatic report(input int t, input bit miss);
    hm_valid = 1; hm_miss = miss; hm_entry = IW'(entry_of[t]);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
      summary();
      $finish;
    end
  end

  initial begin
    int a, b, c, d;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    nxt();
    // R1 reset state
    chk(iss_valid == '0, "R1", "iss_valid after reset", int'(iss_valid), 0);
    chk(full == 1'b0, "R1", "full after reset", int'(full), 0);
    run = 1;

    // Scenario A: load -> alu -> alu chain, late independent op, load hits
    nxt(); a = cyc;
    exp_iss(a+1, 1, 1, 1, "R11");
    exp_iss(a+3, 0, 2, 0, "R4");
    exp_iss(a+4, 0, 3, 0, "R3");
    exp_iss(a+5, 0, 4, 0, "R5");
    alloc(1, 1, 1, -1, -1); nxt();
    alloc(2, 0, 0, 1, -1);  nxt();
    alloc(3, 0, 0, -1, 2);  nxt();
    alloc(4, 0, 0, -1, -1); nxt();
    nxt();
    report(1, 0); nxt();
    repeat (6) nxt();

    // Scenario B: same chain, load misses after two dependents issued
    b = cyc;
    exp_iss(b+1, 1, 5, 1, "R11");
    exp_iss(b+3, 0, 6, 0, "R4");
    exp_iss(b+4, 0, 7, 0, "R3");
    exp_iss(b+5, 0, 8, 0, "R8");
    exp_iss(b+8, 1, 5, 0, "R9");
    exp_iss(b+10, 0, 6, 0, "R9");
    exp_iss(b+11, 0, 7, 0, "R7");
    alloc(5, 1, 1, -1, -1); nxt();
    alloc(6, 0, 0, 5, -1);  nxt();
    alloc(7, 0, 0, 6, -1);  nxt();
    alloc(8, 0, 0, -1, -1); nxt();
    nxt();
    report(5, 1); nxt();
    nxt();
    fill_valid = 1; fill_entry = IW'(entry_of[5]); nxt();
    repeat (8) nxt();

    // Scenario C: closed port holds a ready operation
    c = cyc;
    port_rdy[0] = 0;
    exp_iss(c+3, 0, 9, 0, "R6");
    alloc(9, 0, 0, -1, -1); nxt();
    nxt(); nxt();
    port_rdy[0] = 1; nxt();
    repeat (4) nxt();

    // Scenario D: unconfirmed loads fill every slot
    d = cyc;
    for (int k = 0; k < N; k++) exp_iss(d+k+1, 1, k+1, 1, "R10");
    for (int k = 0; k < N; k++) begin
      chk(full == 1'b0, "R2", "full before last slot", int'(full), 0);
      alloc(k+1, 1, 1, -1, -1); nxt();
    end
    chk(full == 1'b1, "R2", "full with all slots used", int'(full), 1);
    alloc(12, 0, 0, -1, -1); nxt();
    repeat (3) nxt();
    chk(full == 1'b1, "R10", "full held by unconfirmed loads", int'(full), 1);
    for (int k = 0; k < N; k++) begin
      report(k+1, 0); nxt();
    end
    repeat (4) nxt();
    chk(full == 1'b0, "R10", "full after all hits", int'(full), 0);
    repeat (6) nxt();
    chk(q.size() == 0, "R2", "pending expectations", q.size(), 0);

    done = 1;
    summary();
    $finish;
  end
endmodule